// File: doc/BRIEF.md
# Per-Page-Policy Direct-Mapped Data Cache

This block sits between a processor load/store port and a burst-capable external memory bus. Every access arrives with a two-bit page attribute from the address translation unit. The attribute selects one of three handlings: copy-back, write-through or uncached. The cache is direct-mapped with 16 lines of four 32-bit words. Each line has a valid bit and a dirty bit.

A global disable flag makes every access go straight to external memory. While the flag is set, the cache contents are left as they are: nothing is invalidated or rewritten. The flag is written through a strobe. It is also set automatically when the processor enters supervisor mode, unless a keep-enabled flag is held high. A locked load always fetches from external memory. When the page is cacheable and the cache is enabled, the locked load refills the line with the fetched block.

On a line refill, the burst starts at the requested word and wraps around the line. That word is handed to the processor as soon as it arrives. The other three words only go into the storage. A dirty line that must be replaced is first written out as a 4-word burst, starting at word 0.

The processor holds `cpu_req` and its operands steady until `cpu_ready` pulses for one cycle. The load data is valid in that same cycle. On the memory side, `mem_req` stays high for the whole transaction. `mem_addr` carries the byte address of the current beat, and each `mem_ack` completes one beat. A transaction is 4 beats when `mem_burst` is high and 1 beat otherwise.

Top module: `pagepol_dcache`

## Requirements
- R1: A load whose page attribute is 11 (uncached) or 10 (reserved, handled as uncached) performs exactly one single-beat memory read and returns that word. It never hits and never changes the valid, tag or data state of any line.
- R2: A store with attribute 11 or 10 performs exactly one single-beat memory write of the store data and does not allocate a line.
- R3: A cacheable load miss (attribute 00 or 01) reads a 4-beat burst. The beat addresses run from the requested word upward and wrap modulo 4 within the line. All four words are then held in the line.
- R4: During a refill, `cpu_ready` rises in the cycle after the first beat is acknowledged, whatever the first-beat latency. Each request produces exactly one `cpu_ready` pulse, and the pulse lasts one cycle.
- R5: A cacheable, unlocked load that hits causes no memory traffic and returns the stored word with a one-cycle `cpu_ready` response.
- R6: A copy-back (00) store that hits updates the word, marks the line dirty and causes no memory traffic. A copy-back store miss refills the line and then merges the store data into it.
- R7: Replacing a dirty line first writes the old line as a 4-beat burst with words 0,1,2,3, before any refill beat, and only then starts the refill.
- R8: A write-through (01) store always performs one single-beat memory write. On a hit it also updates the cached word. On a miss it does not allocate.
- R9: While `cache_off` is 1, accesses behave as uncached and leave every line untouched. After re-enabling, a line that was valid hits and returns its old stored word, even if memory changed in the meantime.
- R10: A `dis_wr` pulse loads `cache_off` from `dis_val`. A rising edge on `sup_mode` sets `cache_off` on the next cycle, unless `keep_on` is 1.
- R11: A locked load always reads memory. With a cacheable attribute and the cache enabled, it refills the line as in R3, writing back a dirty line first, even on a hit. With an uncached attribute or while disabled, it is a single-beat read.
- R12: After reset, no line is valid, `cache_off` is 0, and `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_policy | input | 2 | Page attribute: 00 copy-back, 01 write-through, 10/11 uncached |
| cpu_lock | input | 1 | Locked load: always read memory |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| sup_mode | input | 1 | Processor is in supervisor mode |
| keep_on | input | 1 | Suppress automatic disable on supervisor entry |
| dis_wr | input | 1 | Write strobe for the disable flag |
| dis_val | input | 1 | Value written to the disable flag |
| cache_off | output | 1 | Current global disable flag |
| mem_req | output | 1 | Memory transaction in progress |
| mem_we | output | 1 | 1 = write transaction |
| mem_burst | output | 1 | 1 = 4-beat line transaction, 0 = single beat |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_wdata | output | DATA_W | Write data of the current beat |
| mem_ack | input | 1 | Current beat completes this cycle |
| mem_rdata | input | DATA_W | Read data of the current beat |

## Verification
Several properties are checked on every cycle:
- `cpu_ready` is a single-cycle pulse.
- `cpu_ready` follows the first refill beat by exactly one cycle.
- An uncached transfer, or any access accepted while disabled, leaves the valid and dirty state unchanged.
- A refill never begins over a dirty line.
- Supervisor entry without `keep_on` turns the cache off.

The remaining behaviours are shown only by the bench's scenarios, compared against a behavioural model of the lines and of memory:
- wrap-around beat order;
- write-back contents;
- store merging;
- stale data returned after re-enable;
- locked-load refill;
- the write-through no-allocate rule.

// File: rtl/pagepol_dcache.sv
`timescale 1ns/1ps
module pagepol_dcache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [1:0]        cpu_policy,
  input  logic              cpu_lock,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sup_mode,
  input  logic              keep_on,
  input  logic              dis_wr,
  input  logic              dis_val,
  output logic              cache_off,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int WPL   = 4;
  localparam int TAG_W = ADDR_W - IDX_W - 4;

  typedef enum logic [2:0] {S_IDLE, S_SRD, S_SWR, S_WB, S_FILL} state_t;

  state_t            state;
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES*WPL];
  logic [ADDR_W-3:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, rdy_q, off_q, sup_q;
  logic [1:0]        beat_q;

  logic [IDX_W-1:0]  r_idx, idx_q;
  logic [TAG_W-1:0]  r_tag, rtag_q;
  logic [1:0]        r_wrd, fill_w;
  logic              r_byp, r_hit, accept, r_wt;
  logic              unused_bits;

  assign r_idx  = cpu_addr[IDX_W+3:4];
  assign r_tag  = cpu_addr[ADDR_W-1:IDX_W+4];
  assign r_wrd  = cpu_addr[3:2];
  assign r_byp  = off_q | cpu_policy[1];
  assign r_wt   = cpu_policy[0];
  assign r_hit  = !r_byp && valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign accept = (state == S_IDLE) && cpu_req && !rdy_q;
  assign unused_bits = ^cpu_addr[1:0];

  assign idx_q  = addr_q[IDX_W+1:2];
  assign rtag_q = addr_q[ADDR_W-3:IDX_W+2];
  assign fill_w = addr_q[1:0] + beat_q;

  assign cpu_ready = rdy_q;
  assign cpu_rdata = rdata_q;
  assign cache_off = off_q;

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_SWR) || (state == S_WB);
  assign mem_burst = (state == S_WB) || (state == S_FILL);
  assign mem_wdata = (state == S_WB) ? data_q[{idx_q, beat_q}] : wdata_q;

  always_comb begin
    case (state)
      S_WB:    mem_addr = {tag_q[idx_q], idx_q, beat_q, 2'b00};
      S_FILL:  mem_addr = {addr_q[ADDR_W-3:2], fill_w, 2'b00};
      default: mem_addr = {addr_q, 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
      rdy_q   <= 1'b0;
      off_q   <= 1'b0;
      sup_q   <= 1'b0;
      beat_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      rdy_q <= 1'b0;
      sup_q <= sup_mode;
      if (dis_wr) off_q <= dis_val;
      if (sup_mode && !sup_q && !keep_on) off_q <= 1'b1;

      case (state)
        S_IDLE: if (accept) begin
          addr_q  <= cpu_addr[ADDR_W-1:2];
          we_q    <= cpu_we;
          wdata_q <= cpu_wdata;
          beat_q  <= '0;
          if (!cpu_we) begin
            if (r_byp) state <= S_SRD;
            else if (r_hit && !cpu_lock) begin
              rdy_q   <= 1'b1;
              rdata_q <= data_q[{r_idx, r_wrd}];
            end else state <= dirty_q[r_idx] ? S_WB : S_FILL;
          end else if (r_byp) begin
            state <= S_SWR;
          end else if (r_wt) begin
            if (r_hit) data_q[{r_idx, r_wrd}] <= cpu_wdata;
            state <= S_SWR;
          end else if (r_hit) begin
            data_q[{r_idx, r_wrd}] <= cpu_wdata;
            dirty_q[r_idx] <= 1'b1;
            rdy_q <= 1'b1;
          end else state <= dirty_q[r_idx] ? S_WB : S_FILL;
        end
        S_SRD: if (mem_ack) begin
          rdata_q <= mem_rdata;
          rdy_q   <= 1'b1;
          state   <= S_IDLE;
        end
        S_SWR: if (mem_ack) begin
          rdy_q <= 1'b1;
          state <= S_IDLE;
        end
        S_WB: if (mem_ack) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) begin
            dirty_q[idx_q] <= 1'b0;
            state <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          data_q[{idx_q, fill_w}] <= (we_q && beat_q == 2'd0) ? wdata_q : mem_rdata;
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd0) begin
            rdy_q   <= 1'b1;
            rdata_q <= mem_rdata;
          end
          if (beat_q == 2'd3) begin
            valid_q[idx_q] <= 1'b1;
            tag_q[idx_q]   <= rtag_q;
            dirty_q[idx_q] <= we_q;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_fill_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ack && beat_q == 2'd0) |=> cpu_ready);

  assert_bypass_no_alloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SRD || state == S_SWR) |=> ($stable(valid_q) && $stable(dirty_q)));

  assert_off_keeps_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && off_q) |=> ($stable(valid_q) && $stable(dirty_q)));

  assert_clean_before_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_FILL) |-> !dirty_q[idx_q]);

  assert_auto_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sup_mode) && !keep_on) |=> cache_off);
endmodule

// File: tb/pagepol_dcache_test.sv
`timescale 1ns/1ps
module pagepol_dcache_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_lock = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0] cpu_policy = '0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic sup_mode = 0, keep_on = 0, dis_wr = 0, dis_val = 0;
  logic cache_off;
  logic mem_req, mem_we, mem_burst;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pagepol_dcache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_policy(cpu_policy), .cpu_lock(cpu_lock), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .sup_mode(sup_mode), .keep_on(keep_on), .dis_wr(dis_wr), .dis_val(dis_val),
    .cache_off(cache_off),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int lat = 1;

  logic [31:0] mem [logic [29:0]];
  logic [31:0] sm  [logic [29:0]];
  bit          m_off = 0;
  bit          mv [16];
  bit          md [16];
  logic [23:0] mt [16];
  logic [31:0] mc [16][4];

  bit          lg_we [$];
  logic [31:0] lg_addr [$];
  logic [31:0] lg_data [$];
  int          lg_cyc [$];
  int          rdy_cnt = 0, rdy_cyc = 0;
  logic [31:0] rdy_data = '0;

  function automatic logic [31:0] init_val(logic [29:0] x);
    return {x[15:0], ~x[15:0]} ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] memr(logic [29:0] x);
    return mem.exists(x) ? mem[x] : init_val(x);
  endfunction
  function automatic logic [31:0] smr(logic [29:0] x);
    return sm.exists(x) ? sm[x] : init_val(x);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor and memory slave, both sampling at the falling edge.
  bit busy = 0;
  int wt = 0, beats = 0;
  always @(negedge clk) begin
    if (cpu_ready) begin
      rdy_cnt++;
      rdy_cyc  = cyc;
      rdy_data = cpu_rdata;
    end
    mem_ack = 1'b0;
    if (mem_req) begin
      if (!busy) begin busy = 1; wt = lat; beats = 0; end
      if (wt > 1) wt--;
      else begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[31:2]] = mem_wdata;
        else mem_rdata = memr(mem_addr[31:2]);
        lg_we.push_back(mem_we);
        lg_addr.push_back(mem_addr);
        lg_data.push_back(mem_we ? mem_wdata : mem_rdata);
        lg_cyc.push_back(cyc);
        beats++;
        if (beats == (mem_burst ? 4 : 1)) busy = 0;
      end
    end else busy = 0;
  end

  task automatic backdoor(input logic [31:0] a, input logic [31:0] v);
    mem[a[31:2]] = v;
    sm[a[31:2]]  = v;
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [1:0] pol, input bit lk, input string rq);
    logic [3:0]  ix;
    logic [1:0]  w;
    logic [23:0] tg;
    logic [29:0] wa;
    bit byp, hit, efill;
    int erd, ewr, nrd, nwr, frd, fwr;
    logic [31:0] ed, vbase;
    logic [31:0] vb [4];
    ix = a[7:4]; w = a[3:2]; tg = a[31:8]; wa = a[31:2];
    erd = 0; ewr = 0; efill = 0; ed = '0; vbase = '0;
    for (int k = 0; k < 4; k++) vb[k] = '0;
    byp = m_off || pol[1];
    hit = !byp && mv[ix] && (mt[ix] == tg);
    if (byp) begin
      if (we) begin ewr = 1; sm[wa] = wd; end
      else begin erd = 1; ed = smr(wa); end
    end else if (!we && hit && !lk) begin
      ed = mc[ix][w];
    end else if (we && hit && pol == 2'b00) begin
      mc[ix][w] = wd; md[ix] = 1;
    end else if (we && pol == 2'b01) begin
      ewr = 1; sm[wa] = wd;
      if (hit) mc[ix][w] = wd;
    end else begin
      if (mv[ix] && md[ix]) begin
        ewr = 4;
        vbase = {mt[ix], ix, 4'h0};
        for (int k = 0; k < 4; k++) begin
          vb[k] = mc[ix][k];
          sm[{mt[ix], ix, 2'(k)}] = mc[ix][k];
        end
      end
      erd = 4; efill = 1;
      for (int k = 0; k < 4; k++) mc[ix][k] = smr({tg, ix, 2'(k)});
      mv[ix] = 1; mt[ix] = tg; md[ix] = 0;
      ed = mc[ix][w];
      if (we) begin mc[ix][w] = wd; md[ix] = 1; end
    end

    lg_we.delete(); lg_addr.delete(); lg_data.delete(); lg_cyc.delete();
    rdy_cnt = 0;
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_policy = pol; cpu_lock = lk;
    while (rdy_cnt == 0) begin @(posedge clk); #1; end
    cpu_req = 0;
    while (mem_req) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end

    nrd = 0; nwr = 0; frd = -1; fwr = -1;
    foreach (lg_we[i]) begin
      if (lg_we[i]) begin if (fwr < 0) fwr = i; nwr++; end
      else begin if (frd < 0) frd = i; nrd++; end
    end
    chk(rdy_cnt == 1, rq, "ready pulses (R4)", rdy_cnt, 1);
    chk(nrd == erd, rq, "read beats", nrd, erd);
    chk(nwr == ewr, rq, "write beats", nwr, ewr);
    if (!we) chk(rdy_data == ed, rq, "load data", rdy_data, ed);
    if (nrd == erd && nwr == ewr) begin
      if (erd == 1) chk(lg_addr[frd] == {a[31:2], 2'b00}, rq, "single read addr", lg_addr[frd], {a[31:2], 2'b00});
      if (ewr == 1) begin
        chk(lg_addr[fwr] == {a[31:2], 2'b00}, rq, "single write addr", lg_addr[fwr], {a[31:2], 2'b00});
        chk(lg_data[fwr] == wd, rq, "single write data", lg_data[fwr], wd);
      end
      if (ewr == 4) begin
        chk(fwr == 0 && frd == 4, rq, "write-back precedes refill (R7)", frd, 4);
        for (int k = 0; k < 4; k++) begin
          chk(lg_addr[k] == vbase + 32'(4*k), rq, "write-back addr (R7)", lg_addr[k], vbase + 32'(4*k));
          chk(lg_data[k] == vb[k], rq, "write-back data (R7)", lg_data[k], vb[k]);
        end
      end
      if (efill) begin
        for (int k = 0; k < 4; k++) begin
          logic [1:0] ww;
          ww = w + 2'(k);
          chk(lg_addr[frd+k] == {a[31:4], ww, 2'b00}, rq, "refill beat order (R3)",
              lg_addr[frd+k], {a[31:4], ww, 2'b00});
        end
        chk(rdy_cyc == lg_cyc[frd] + 1, rq, "first word forwarded (R4)", rdy_cyc, lg_cyc[frd] + 1);
      end
    end
  endtask

  task automatic set_dis(input bit v, input string rq);
    @(posedge clk); #1; dis_wr = 1; dis_val = v;
    @(posedge clk); #1; dis_wr = 0; m_off = v;
    chk(cache_off == m_off, rq, "cache_off after write", cache_off, m_off);
  endtask

  task automatic set_sup(input bit v, input string rq);
    bit prev;
    prev = sup_mode;
    @(posedge clk); #1; sup_mode = v;
    if (v && !prev && !keep_on) m_off = 1;
    @(posedge clk); #1;
    chk(cache_off == m_off, rq, "cache_off after mode change", cache_off, m_off);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] pool [7];
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(cpu_ready == 0, "R12", "ready after reset", cpu_ready, 0);
    chk(mem_req == 0, "R12", "mem_req after reset", mem_req, 0);
    chk(cache_off == 0, "R12", "cache_off after reset", cache_off, 0);

    lat = 3; access(0, 32'h0000_1048, 0, 2'b00, 0, "R3 R12 load miss fills");
    lat = 1; access(0, 32'h0000_104C, 0, 2'b00, 0, "R5 load hit");
    access(1, 32'h0000_1048, 32'hDEAD_0001, 2'b00, 0, "R6 copy-back store hit");
    access(0, 32'h0000_1048, 0, 2'b00, 0, "R6 read back dirty word");
    lat = 4; access(0, 32'h0000_2048, 0, 2'b00, 0, "R7 dirty eviction");
    lat = 2; access(0, 32'h0000_1048, 0, 2'b11, 0, "R1 uncached sees written-back word");

    access(1, 32'h0000_2044, 32'hBEEF_0002, 2'b01, 0, "R8 write-through hit");
    access(0, 32'h0000_2044, 0, 2'b00, 0, "R8 hit after write-through");
    access(1, 32'h0000_3050, 32'hBEEF_0003, 2'b01, 0, "R8 write-through miss");
    access(0, 32'h0000_3050, 0, 2'b00, 0, "R8 no allocate on write-through miss");

    backdoor(32'h0000_3054, 32'h1111_2222);
    access(0, 32'h0000_3054, 0, 2'b11, 0, "R1 uncached load");
    access(0, 32'h0000_3054, 0, 2'b10, 0, "R1 reserved acts uncached");
    access(0, 32'h0000_3054, 0, 2'b00, 0, "R1 line untouched by uncached");
    access(1, 32'h0000_3054, 32'h3333_4444, 2'b11, 0, "R2 uncached store");
    access(0, 32'h0000_3054, 0, 2'b00, 0, "R2 no allocate on uncached store");

    set_dis(1, "R10 R9");
    access(0, 32'h0000_2044, 0, 2'b00, 0, "R9 disabled load bypasses");
    backdoor(32'h0000_2040, 32'h5555_6666);
    access(1, 32'h0000_2048, 32'h7777_8888, 2'b00, 0, "R9 disabled store bypasses");
    set_dis(0, "R10 R9");
    access(0, 32'h0000_2040, 0, 2'b00, 0, "R9 stale hit after re-enable");
    access(0, 32'h0000_2048, 0, 2'b00, 0, "R9 stale word kept");

    lat = 3; access(0, 32'h0000_2040, 0, 2'b00, 1, "R11 locked load on hit refills");
    lat = 1; access(0, 32'h0000_2048, 0, 2'b00, 0, "R11 refilled line hits");
    access(0, 32'h0000_2048, 0, 2'b11, 1, "R11 locked uncached single read");

    set_sup(1, "R10 auto disable");
    set_sup(0, "R10");
    set_dis(0, "R10");
    keep_on = 1;
    set_sup(1, "R10 keep enabled");
    set_sup(0, "R10");
    keep_on = 0;

    access(1, 32'h0000_4054, 32'hCAFE_0005, 2'b00, 0, "R6 copy-back store miss allocates");
    access(0, 32'h0000_4054, 0, 2'b00, 0, "R6 merged word");
    lat = 4; access(0, 32'h0000_505C, 0, 2'b00, 0, "R7 merged line written back");

    pool[0] = 32'h0000_1048; pool[1] = 32'h0000_2048; pool[2] = 32'h0000_3050;
    pool[3] = 32'h0000_4054; pool[4] = 32'h0000_505C; pool[5] = 32'h0000_104C;
    pool[6] = 32'h0000_6040;
    lcg = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [1:0] pp;
      bit wr, lk;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pp = (lcg[20:18] < 3'd4) ? 2'b00 : (lcg[20:18] < 3'd6) ? 2'b01 : lcg[19:18];
      wr = lcg[23];
      lk = !wr && (lcg[27:25] == 3'd0);
      lat = 1 + int'(lcg[29:28]);
      access(wr, pool[int'(lcg[16:14]) % 7], lcg ^ 32'h0F0F_0000, pp, lk, "R3 R5 R6 R8 mixed");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule